// File: doc/BRIEF.md
# Multi-Flag Doorbell Channel Array

This block holds an array of one-way doorbell channels that link a sender register port to a receiver register port. Every channel keeps a 32-bit flag word. Each flag stands for one event notification. The sender raises flags by writing a mask of ones. The receiver sees a per-channel transfer interrupt while any flag of that channel is up. It services the events and writes a mask of ones to drop the flags it has handled. When a channel's flag word falls from non-zero to zero, the sender gets a sticky acknowledge status and a per-channel acknowledge interrupt. The sender clears that status with a write-one-to-clear.

Each side has a per-channel enable mask. The mask gates that side's individual interrupt lines and its combined line. All interrupts are level outputs.

Both ports are plain synchronous write strobes with combinational read data. The word address is split into a 2-bit register select in the upper bits and a channel index in the lower bits. Each channel runs a two-state machine:

- CH_IDLE: the flag word is zero.
- CH_BUSY: at least one flag is pending.

The channel moves IDLE to BUSY when its next flag word is non-zero. It moves BUSY to IDLE when its next flag word is zero, and that BUSY-to-IDLE step raises the acknowledge status.

Top module: `db_array`

## Requirements
- R1: After reset all flag words read 0, all masks and acknowledge statuses are 0, and every interrupt output is low.
- R2: A sender write to select 0 (flag word) of channel c sets each flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged. Several flags can be raised in one write.
- R3: A receiver write to select 0 of channel c clears each flag whose data bit is 1 and leaves the other flags unchanged.
- R4: When a sender set and a receiver clear hit the same flag in the same cycle, the flag ends up set.
- R5: r_xfer_irq[c] is high when channel c has any flag pending and bit 0 of the receiver mask (select 2) for c is 1. Otherwise it is low.
- R6: When a channel's flag word goes from non-zero to zero, its acknowledge status (sender select 1, bit 0) becomes 1. It stays 1 until the sender writes 1 to bit 0 of select 1. If that clear lands in the same cycle as a new acknowledge event, the status stays 1.
- R7: s_ack_irq[c] is high when the acknowledge status of channel c is 1 and bit 0 of the sender mask (select 2) for c is 1.
- R8: r_comb_irq is the OR of all r_xfer_irq bits, and s_comb_irq is the OR of all s_ack_irq bits.
- R9: Either port reads the current flag word of any channel at select 0, combinationally from its address.
- R10: Select 3 on either port reads the channel count NUM_CH, and writes to it have no effect.
- R11: A write changes only the addressed channel. Flag words do not change in a cycle with no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_wr | input | 1 | Sender write strobe |
| s_addr | input | ADDR_W | Sender address {select[1:0], channel} |
| s_wdata | input | 32 | Sender write data |
| s_rdata | output | 32 | Sender read data |
| r_wr | input | 1 | Receiver write strobe |
| r_addr | input | ADDR_W | Receiver address {select[1:0], channel} |
| r_wdata | input | 32 | Receiver write data |
| r_rdata | output | 32 | Receiver read data |
| r_xfer_irq | output | NUM_CH | Per-channel transfer interrupt to receiver |
| r_comb_irq | output | 1 | Combined receiver interrupt |
| s_ack_irq | output | NUM_CH | Per-channel acknowledge interrupt to sender |
| s_comb_irq | output | 1 | Combined sender interrupt |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a sender set and a receiver clear of the same flag. The second pair is the receiver emptying a channel while the sender write-one-clears that channel's acknowledge status. The bench provokes each pair by strobing both ports on the same clock edge. It then judges the outcome at the ports: the flag must read back as set, and the acknowledge status must read 1 and keep the sender interrupt high, with set winning in both cases.

// File: rtl/db_pkg.sv
`timescale 1ns/1ps
package db_pkg;
    parameter int FLAG_W = 32;

    typedef enum logic [1:0] {
        SEL_FLAG  = 2'd0,
        SEL_ACK   = 2'd1,
        SEL_MASK  = 2'd2,
        SEL_COUNT = 2'd3
    } reg_sel_e;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_BUSY = 1'b1
    } ch_state_e;
endpackage

// File: rtl/db_channel.sv
`timescale 1ns/1ps
module db_channel
    import db_pkg::*;
#(
    parameter int FW = FLAG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] set_i,
    input  logic [FW-1:0] clr_i,
    input  logic          ack_clr_i,
    output logic [FW-1:0] flags_o,
    output logic          ack_o
);
    ch_state_e     state_q, state_nx;
    logic [FW-1:0] flags_q, flags_nx;
    logic          ack_q, ack_nx, ack_evt;

    // set wins over clear on the same flag
    always_comb begin
        flags_nx = (flags_q & ~clr_i) | set_i;
        state_nx = state_q;
        ack_evt  = 1'b0;
        unique case (state_q)
            CH_IDLE: if (flags_nx != '0) state_nx = CH_BUSY;
            CH_BUSY: if (flags_nx == '0) begin
                state_nx = CH_IDLE;
                ack_evt  = 1'b1;
            end
            default: state_nx = CH_IDLE;
        endcase
        ack_nx = ack_evt | (ack_q & ~ack_clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            flags_q <= '0;
            ack_q   <= 1'b0;
        end else begin
            state_q <= state_nx;
            flags_q <= flags_nx;
            ack_q   <= ack_nx;
        end
    end

    always_comb begin
        flags_o = flags_q;
        ack_o   = ack_q;
    end
endmodule

// File: rtl/db_irq_gate.sv
`timescale 1ns/1ps
module db_irq_gate #(
    parameter int N = 8
) (
    input  logic [N-1:0] src_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] irq_o,
    output logic         any_o
);
    for (genvar i = 0; i < N; i++) begin : g_line
        assign irq_o[i] = src_i[i] & en_i[i];
    end
    assign any_o = |irq_o;
endmodule

// File: rtl/db_array.sv
`timescale 1ns/1ps
module db_array
    import db_pkg::*;
#(
    parameter int  NUM_CH = 8,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = CH_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_wr,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [31:0]       s_wdata,
    output logic [31:0]       s_rdata,
    input  logic              r_wr,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [31:0]       r_wdata,
    output logic [31:0]       r_rdata,
    output logic [NUM_CH-1:0] r_xfer_irq,
    output logic              r_comb_irq,
    output logic [NUM_CH-1:0] s_ack_irq,
    output logic              s_comb_irq
);
    reg_sel_e          s_sel, r_sel;
    logic [CH_W-1:0]   s_ch, r_ch;
    logic              s_ch_ok, r_ch_ok;
    logic [FLAG_W-1:0] flag_w [NUM_CH];
    logic [NUM_CH*FLAG_W-1:0] flag_flat;
    logic [NUM_CH-1:0] ack_vec, pend_vec;
    logic [NUM_CH-1:0] s_mask_q, r_mask_q;

    assign s_sel   = reg_sel_e'(s_addr[ADDR_W-1 -: 2]);
    assign r_sel   = reg_sel_e'(r_addr[ADDR_W-1 -: 2]);
    assign s_ch    = s_addr[CH_W-1:0];
    assign r_ch    = r_addr[CH_W-1:0];
    assign s_ch_ok = (32'(s_ch) < NUM_CH);
    assign r_ch_ok = (32'(r_ch) < NUM_CH);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic s_hit, r_hit;
        assign s_hit = s_wr && (s_ch == CH_W'(c));
        assign r_hit = r_wr && (r_ch == CH_W'(c));

        db_channel #(.FW(FLAG_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_i     ((s_hit && s_sel == SEL_FLAG) ? s_wdata : '0),
            .clr_i     ((r_hit && r_sel == SEL_FLAG) ? r_wdata : '0),
            .ack_clr_i (s_hit && s_sel == SEL_ACK && s_wdata[0]),
            .flags_o   (flag_w[c]),
            .ack_o     (ack_vec[c])
        );

        assign flag_flat[c*FLAG_W +: FLAG_W] = flag_w[c];
        assign pend_vec[c] = |flag_w[c];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s_mask_q[c] <= 1'b0;
                r_mask_q[c] <= 1'b0;
            end else begin
                if (s_hit && s_sel == SEL_MASK) s_mask_q[c] <= s_wdata[0];
                if (r_hit && r_sel == SEL_MASK) r_mask_q[c] <= r_wdata[0];
            end
        end
    end

    always_comb begin
        s_rdata = '0;
        unique case (s_sel)
            SEL_FLAG:  if (s_ch_ok) s_rdata = flag_w[s_ch];
            SEL_ACK:   if (s_ch_ok) s_rdata = {31'd0, ack_vec[s_ch]};
            SEL_MASK:  if (s_ch_ok) s_rdata = {31'd0, s_mask_q[s_ch]};
            SEL_COUNT: s_rdata = 32'(NUM_CH);
            default:   s_rdata = '0;
        endcase
    end

    always_comb begin
        r_rdata = '0;
        unique case (r_sel)
            SEL_FLAG:  if (r_ch_ok) r_rdata = flag_w[r_ch];
            SEL_ACK:   r_rdata = '0;
            SEL_MASK:  if (r_ch_ok) r_rdata = {31'd0, r_mask_q[r_ch]};
            SEL_COUNT: r_rdata = 32'(NUM_CH);
            default:   r_rdata = '0;
        endcase
    end

    db_irq_gate #(.N(NUM_CH)) u_rx_irq (
        .src_i (pend_vec),
        .en_i  (r_mask_q),
        .irq_o (r_xfer_irq),
        .any_o (r_comb_irq)
    );

    db_irq_gate #(.N(NUM_CH)) u_tx_irq (
        .src_i (ack_vec),
        .en_i  (s_mask_q),
        .irq_o (s_ack_irq),
        .any_o (s_comb_irq)
    );
endmodule

// File: rtl/db_array_chk.sv
`timescale 1ns/1ps
module db_array_chk #(
    parameter int  NUM_CH = 8,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = CH_W + 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_wr,
    input logic [ADDR_W-1:0] s_addr,
    input logic [31:0]       s_wdata,
    input logic [31:0]       s_rdata,
    input logic              r_wr,
    input logic [ADDR_W-1:0] r_addr,
    input logic [31:0]       r_wdata,
    input logic [NUM_CH*32-1:0] flag_flat,
    input logic [NUM_CH-1:0] ack_vec,
    input logic [NUM_CH-1:0] r_mask_q,
    input logic [NUM_CH-1:0] r_xfer_irq,
    input logic              r_comb_irq
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (s_wr && s_addr == {2'd0, CH_W'(c)})
            |=> ((flag_flat[c*32 +: 32] & $past(s_wdata)) == $past(s_wdata)));

        assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (r_wr && r_addr == {2'd0, CH_W'(c)} && !(s_wr && s_addr == r_addr))
            |=> ((flag_flat[c*32 +: 32] & $past(r_wdata)) == 32'd0));

        assert_ack_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(|flag_flat[c*32 +: 32]) |-> ack_vec[c]);

        assert_rx_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !r_mask_q[c] |-> !r_xfer_irq[c]);
    end

    assert_no_spont_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_wr && !r_wr) |=> $stable(flag_flat));

    assert_comb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        r_comb_irq == (|r_xfer_irq));

    assert_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_addr[ADDR_W-1 -: 2] == 2'd3) |-> (s_rdata == 32'(NUM_CH)));
endmodule

bind db_array db_array_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .s_wr       (s_wr),
    .s_addr     (s_addr),
    .s_wdata    (s_wdata),
    .s_rdata    (s_rdata),
    .r_wr       (r_wr),
    .r_addr     (r_addr),
    .r_wdata    (r_wdata),
    .flag_flat  (flag_flat),
    .ack_vec    (ack_vec),
    .r_mask_q   (r_mask_q),
    .r_xfer_irq (r_xfer_irq),
    .r_comb_irq (r_comb_irq)
);

// File: tb/db_array_test.sv
`timescale 1ns/1ps
module db_array_test;
    localparam int NCH = 8;
    localparam int AW  = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           s_wr = 1'b0, r_wr = 1'b0;
    logic [AW-1:0]  s_addr = '0, r_addr = '0;
    logic [31:0]    s_wdata = '0, r_wdata = '0;
    logic [31:0]    s_rdata, r_rdata;
    logic [NCH-1:0] r_xfer_irq, s_ack_irq;
    logic           r_comb_irq, s_comb_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    db_array #(.NUM_CH(NCH)) uut (
        .clk(clk), .rst_n(rst_n),
        .s_wr(s_wr), .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata),
        .r_wr(r_wr), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
        .r_xfer_irq(r_xfer_irq), .r_comb_irq(r_comb_irq),
        .s_ack_irq(s_ack_irq), .s_comb_irq(s_comb_irq)
    );

    // {side(0=sender,1=receiver), ch[2:0], data[31:0], expected flag word[31:0]}
    localparam logic [67:0] VEC [8] = '{
        {1'b0, 3'd0, 32'h0000_0001, 32'h0000_0001},
        {1'b0, 3'd0, 32'h8000_0010, 32'h8000_0011},
        {1'b0, 3'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {1'b1, 3'd0, 32'h0000_0010, 32'h8000_0001},
        {1'b1, 3'd0, 32'h0000_0000, 32'h8000_0001},
        {1'b0, 3'd0, 32'h0000_0000, 32'h8000_0001},
        {1'b1, 3'd7, 32'h0F0F_0F0F, 32'hF0F0_F0F0},
        {1'b0, 3'd3, 32'hA5A5_0000, 32'hA5A5_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input bit side, input logic [1:0] sel, input logic [2:0] ch,
                      input logic [31:0] d);
        @(negedge clk);
        if (side) begin r_wr = 1'b1; r_addr = {sel, ch}; r_wdata = d; end
        else      begin s_wr = 1'b1; s_addr = {sel, ch}; s_wdata = d; end
        @(negedge clk);
        s_wr = 1'b0; r_wr = 1'b0;
    endtask

    task automatic wr_both(input logic [1:0] ssel, input logic [2:0] sch, input logic [31:0] sd,
                           input logic [1:0] rsel, input logic [2:0] rch, input logic [31:0] rd);
        @(negedge clk);
        s_wr = 1'b1; s_addr = {ssel, sch}; s_wdata = sd;
        r_wr = 1'b1; r_addr = {rsel, rch}; r_wdata = rd;
        @(negedge clk);
        s_wr = 1'b0; r_wr = 1'b0;
    endtask

    task automatic rd_s(input logic [1:0] sel, input logic [2:0] ch, output logic [31:0] v);
        s_addr = {sel, ch}; #1; v = s_rdata;
    endtask

    task automatic rd_r(input logic [1:0] sel, input logic [2:0] ch, output logic [31:0] v);
        r_addr = {sel, ch}; #1; v = r_rdata;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int c = 0; c < NCH; c++) begin
            rd_s(2'd0, 3'(c), v); chk("R1 flags", v, 32'd0);
            rd_s(2'd1, 3'(c), v); chk("R1 ack", v, 32'd0);
            rd_s(2'd2, 3'(c), v); chk("R1 smask", v, 32'd0);
        end
        chk("R1 irqs", {14'd0, r_xfer_irq, s_ack_irq, r_comb_irq, s_comb_irq}, 32'd0);

        // R2 R3 R11 vector walk
        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][67], 2'd0, VEC[i][66:64], VEC[i][63:32]);
            rd_s(2'd0, VEC[i][66:64], v);
            chk(VEC[i][67] ? "R3 clear" : "R2 set", v, VEC[i][31:0]);
        end
        rd_s(2'd0, 3'd1, v); chk("R11 untouched ch1", v, 32'd0);
        rd_s(2'd0, 3'd0, v); chk("R11 ch0 kept", v, 32'h8000_0001);
        rd_s(2'd1, 3'd0, v); chk("R6 no ack while pending", v, 32'd0);

        // R9 receiver reads
        rd_r(2'd0, 3'd7, v); chk("R9 rx read ch7", v, 32'hF0F0_F0F0);
        rd_r(2'd0, 3'd3, v); chk("R9 rx read ch3", v, 32'hA5A5_0000);

        // R5 receiver interrupt gating
        chk("R5 masked", {24'd0, r_xfer_irq}, 32'd0);
        chk("R8 rx comb masked", {31'd0, r_comb_irq}, 32'd0);
        wr(1'b1, 2'd2, 3'd3, 32'd1);
        chk("R5 enabled", {24'd0, r_xfer_irq}, 32'h08);
        chk("R8 rx comb", {31'd0, r_comb_irq}, 32'd1);

        // R4 set and clear on the same flag in one cycle
        wr_both(2'd0, 3'd3, 32'h0000_0001, 2'd0, 3'd3, 32'h0000_0001);
        rd_s(2'd0, 3'd3, v); chk("R4 set wins", v, 32'hA5A5_0001);

        // R6 R7 acknowledge path
        wr(1'b1, 2'd0, 3'd3, 32'hFFFF_FFFF);
        rd_s(2'd0, 3'd3, v); chk("R3 emptied", v, 32'd0);
        chk("R5 idle", {24'd0, r_xfer_irq}, 32'd0);
        rd_s(2'd1, 3'd3, v); chk("R6 ack raised", v, 32'd1);
        chk("R7 ack masked", {24'd0, s_ack_irq}, 32'd0);
        wr(1'b0, 2'd2, 3'd3, 32'd1);
        chk("R7 ack irq", {24'd0, s_ack_irq}, 32'h08);
        chk("R8 tx comb", {31'd0, s_comb_irq}, 32'd1);
        wr(1'b0, 2'd1, 3'd3, 32'd1);
        rd_s(2'd1, 3'd3, v); chk("R6 ack cleared", v, 32'd0);
        chk("R8 tx comb low", {31'd0, s_comb_irq}, 32'd0);

        // R6 clear and new event in the same cycle
        wr(1'b0, 2'd2, 3'd0, 32'd1);
        wr_both(2'd1, 3'd0, 32'd1, 2'd0, 3'd0, 32'hFFFF_FFFF);
        rd_s(2'd1, 3'd0, v); chk("R6 event beats clear", v, 32'd1);
        chk("R7 irq held", {24'd0, s_ack_irq}, 32'h01);
        wr(1'b0, 2'd1, 3'd0, 32'd1);
        rd_s(2'd1, 3'd0, v); chk("R6 later clear", v, 32'd0);

        // R10 channel count
        rd_s(2'd3, 3'd0, v); chk("R10 tx count", v, 32'd8);
        rd_r(2'd3, 3'd5, v); chk("R10 rx count", v, 32'd8);
        wr(1'b0, 2'd3, 3'd0, 32'hFFFF_FFFF);
        rd_s(2'd3, 3'd0, v); chk("R10 count write ignored", v, 32'd8);
        rd_s(2'd0, 3'd0, v); chk("R10 no flag side effect", v, 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule